// File: doc/BRIEF.md
# Cascadable Octal Priority Encoder with 16-Line Chain

Each octal stage looks at eight active-low request lines and picks the highest-numbered line that is asserted. Line 7 wins over every other line, and line 0 wins over none. The stage reports the winner's 3-bit index in inverted form. An active-low group output tells whether any line in the stage is asserted. An active-low enable output goes low only when the stage is enabled and none of its lines is asserted. That enable output is meant to drive the enable input of the next stage down in priority, so stages chain with no glue logic.

The top level chains two stages into a 16-line encoder. The upper stage takes lines 15 to 8 and its idle output enables the lower stage. The low three code bits merge the two stages' addresses. The upper stage's group output supplies the most significant code bit. The combined flag shows that some line in either stage is asserted. A parameter selects whether the code and flag leave the block active-low or active-high.

The merged code and flag are captured in an output register, which is clocked. A combinational encoder can give a wrong address or a short false flag while its inputs are changing. The register samples the code and flag once per cycle, after they have settled, so the outputs are clean.

Top module: `penc16_top`

## Requirements
- R1: In a stage that is enabled, the address output equals the bitwise inverse of the index of the highest asserted (low) line. Line 7 is the highest and line 0 the lowest, and lines below the winner have no effect.
- R2: When a stage's enable input is high, its address is 3'b111 and its group and idle outputs are both high, whatever the request lines are.
- R3: When a stage is enabled and no request line is low, its address is 3'b111, its group output is high and its idle output is low.
- R4: When a stage is enabled and at least one request line is low, its group output is low and its idle output is high.
- R5: When the 16-line encoder is enabled, its code is the 4-bit index of the highest low line among lines 15 down to 0, with line 15 the highest. Code bit 3 is 1 exactly when one of lines 15 to 8 is low.
- R6: The 16-line flag is in its asserted state exactly when the enable input is low and at least one of the 16 lines is low.
- R7: With ACTIVE_HIGH = 0, the code pins carry the inverted index and a low flag means a hit. The idle value is code 4'b1111 with flag 1. With ACTIVE_HIGH = 1, the code pins carry the index itself and a high flag means a hit. The idle value is code 4'b0000 with flag 0.
- R8: The code and flag are registered. They reflect the inputs present at the previous rising clock edge. While reset is active, both outputs hold their idle value.
- R9: When the 16-line enable input is high, the code and flag take their idle value one clock later, whatever the request lines are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised to clk |
| en_n | input | 1 | Active-low enable of the chain (drives the upper stage) |
| req_n | input | 16 | Active-low request lines; bit 15 has the highest priority |
| code | output | 4 | Registered index of the winning line, polarity set by ACTIVE_HIGH |
| flag | output | 1 | Registered hit flag, polarity set by ACTIVE_HIGH |

## Verification
The octal stage has no clock, so every stage result is due as soon as its inputs settle. The bench applies each of the 512 enable and data combinations and reads the stage outputs one nanosecond later. The 16-line code and flag are due one rising edge after the inputs are applied. The bench changes the inputs on a falling edge and compares the outputs on the following falling edge. That way each comparison sees exactly one register update for the vector under test. The bench checks reset first, after the two-stage reset release has passed, and only then starts checking latency.

// File: rtl/penc_pkg.sv
package penc_pkg;
  localparam int unsigned STAGE_LINES = 8;
  localparam int unsigned STAGE_IDXW  = $clog2(STAGE_LINES);
  localparam int unsigned CHAIN_LINES = 2 * STAGE_LINES;
  localparam int unsigned CHAIN_CODEW = STAGE_IDXW + 1;

  typedef struct packed {
    logic [STAGE_IDXW-1:0] addr_n;
    logic                  grp_n;
    logic                  idle_n;
  } stage_res_t;
endpackage

// File: rtl/penc_stage.sv
module penc_stage
  import penc_pkg::*;
#(
  parameter int unsigned LINES = STAGE_LINES,
  localparam int unsigned IDXW = $clog2(LINES)
) (
  input  logic [LINES-1:0] req_n,
  input  logic             en_n,
  output logic [IDXW-1:0]  addr_n,
  output logic             grp_n,
  output logic             idle_n
);
  logic            hit;
  logic [IDXW-1:0] idx;

  // scan upward so the highest asserted line overrides lower ones
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!req_n[i]) begin
        hit = 1'b1;
        idx = IDXW'(i);
      end
    end
  end

  always_comb begin
    addr_n = en_n ? {IDXW{1'b1}} : ~idx;
    grp_n  = en_n | ~hit;
    idle_n = en_n | hit;
  end
endmodule

// File: rtl/penc_merge.sv
module penc_merge
  import penc_pkg::*;
#(
  parameter int unsigned IDXW = STAGE_IDXW,
  localparam int unsigned CODEW = IDXW + 1
) (
  input  logic [IDXW-1:0]  hi_addr_n,
  input  logic             hi_grp_n,
  input  logic [IDXW-1:0]  lo_addr_n,
  input  logic             lo_grp_n,
  output logic [CODEW-1:0] code_n,
  output logic             flag_n
);
  // the disabled stage drives all ones, so an active-low AND selects the live one
  always_comb begin
    code_n = {hi_grp_n, hi_addr_n & lo_addr_n};
    flag_n = hi_grp_n & lo_grp_n;
  end
endmodule

// File: rtl/penc16_top.sv
module penc16_top
  import penc_pkg::*;
#(
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_n,
  input  logic [CHAIN_LINES-1:0] req_n,
  output logic [CHAIN_CODEW-1:0] code,
  output logic                   flag
);
  localparam logic [CHAIN_CODEW-1:0] CODE_IDLE = ACTIVE_HIGH ? '0 : '1;
  localparam logic                   FLAG_IDLE = ~ACTIVE_HIGH;

  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  stage_res_t hi_res, lo_res;

  penc_stage #(.LINES(STAGE_LINES)) u_hi (
    .req_n (req_n[CHAIN_LINES-1:STAGE_LINES]),
    .en_n  (en_n),
    .addr_n(hi_res.addr_n),
    .grp_n (hi_res.grp_n),
    .idle_n(hi_res.idle_n)
  );

  penc_stage #(.LINES(STAGE_LINES)) u_lo (
    .req_n (req_n[STAGE_LINES-1:0]),
    .en_n  (hi_res.idle_n),
    .addr_n(lo_res.addr_n),
    .grp_n (lo_res.grp_n),
    .idle_n(lo_res.idle_n)
  );

  logic [CHAIN_CODEW-1:0] code_n_w;
  logic                   flag_n_w;

  penc_merge #(.IDXW(STAGE_IDXW)) u_merge (
    .hi_addr_n(hi_res.addr_n),
    .hi_grp_n (hi_res.grp_n),
    .lo_addr_n(lo_res.addr_n),
    .lo_grp_n (lo_res.grp_n),
    .code_n   (code_n_w),
    .flag_n   (flag_n_w)
  );

  logic [CHAIN_CODEW-1:0] code_d, code_q;
  logic                   flag_d, flag_q, primed_q;
  logic                   load;

  generate
    if (ACTIVE_HIGH) begin : g_pos
      always_comb begin
        code_d = ~code_n_w;
        flag_d = ~flag_n_w;
      end
    end else begin : g_neg
      always_comb begin
        code_d = code_n_w;
        flag_d = flag_n_w;
      end
    end
  endgenerate

  assign load = 1'b1;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      code_q   <= CODE_IDLE;
      flag_q   <= FLAG_IDLE;
      primed_q <= 1'b0;
    end else if (load) begin
      code_q   <= code_d;
      flag_q   <= flag_d;
      primed_q <= 1'b1;
    end
  end

  assign code = code_q;
  assign flag = flag_q;

  logic [CHAIN_CODEW-1:0] idx_seen;
  logic                   hit_seen;
  assign idx_seen = ACTIVE_HIGH ? code_q : ~code_q;
  assign hit_seen = ACTIVE_HIGH ? flag_q : ~flag_q;

  // R6
  flag_hit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    primed_q |-> (hit_seen == ($past(!en_n) && $past(req_n != '1))));

  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (primed_q && $past(en_n)) |-> (code_q == CODE_IDLE && flag_q == FLAG_IDLE));

  // R5
  top_line_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (primed_q && $past(!en_n && !req_n[CHAIN_LINES-1])) |-> (idx_seen == '1));

  // R5
  upper_bit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (primed_q && $past(!en_n && req_n[CHAIN_LINES-1:STAGE_LINES] != '1))
      |-> idx_seen[CHAIN_CODEW-1]);

  // R5
  lower_bit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (primed_q && $past(!en_n && req_n[CHAIN_LINES-1:STAGE_LINES] == '1))
      |-> !idx_seen[CHAIN_CODEW-1]);
endmodule

// File: tb/penc16_top_test.sv
`timescale 1ns/100ps
module penc16_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_n;
  logic [15:0] req_n;
  logic [3:0]  code_lo, code_hi;
  logic        flag_lo, flag_hi;

  logic [7:0]  s_req_n;
  logic        s_en_n;
  logic [2:0]  s_addr_n;
  logic        s_grp_n, s_idle_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  penc16_top #(.ACTIVE_HIGH(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .req_n(req_n),
    .code(code_lo), .flag(flag_lo));

  penc16_top #(.ACTIVE_HIGH(1'b1)) uut_pos (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .req_n(req_n),
    .code(code_hi), .flag(flag_hi));

  penc_stage #(.LINES(8)) uut_stage (
    .req_n(s_req_n), .en_n(s_en_n),
    .addr_n(s_addr_n), .grp_n(s_grp_n), .idle_n(s_idle_n));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {addr_n, grp_n, idle_n}
  function automatic logic [4:0] ref_stage(input logic en, input logic [7:0] rq);
    logic [2:0] win = 3'd0;
    logic any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      if (!any && !rq[i]) begin
        any = 1'b1;
        win = 3'(i);
      end
    end
    if (en) return 5'b11111;
    if (!any) return {3'b111, 1'b1, 1'b0};
    return {~win, 1'b0, 1'b1};
  endfunction

  // {code, flag} for the chosen polarity
  function automatic logic [4:0] ref_chain(input logic en, input logic [15:0] rq, input bit pos);
    logic [3:0] win = 4'd0;
    logic any = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      if (!any && !rq[i]) begin
        any = 1'b1;
        win = 4'(i);
      end
    end
    if (en || !any) return pos ? 5'b00000 : 5'b11111;
    return pos ? {win, 1'b1} : {~win, 1'b0};
  endfunction

  task automatic apply(input logic en, input logic [15:0] rq, input string tag);
    logic [4:0] e0, e1;
    @(negedge clk);
    en_n  = en;
    req_n = rq;
    e0 = ref_chain(en, rq, 1'b0);
    e1 = ref_chain(en, rq, 1'b1);
    @(negedge clk);
    chk({tag, " code active-low R7"}, code_lo, e0[4:1]);
    chk({tag, " flag active-low R6"}, flag_lo, e0[0]);
    chk({tag, " code active-high R7"}, code_hi, e1[4:1]);
    chk({tag, " flag active-high R6"}, flag_hi, e1[0]);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] se;
    void'($urandom(32'd5171));
    rst_n = 1'b0;
    en_n  = 1'b0;
    req_n = 16'h0000;
    s_en_n = 1'b1;
    s_req_n = 8'hFF;
    repeat (3) @(negedge clk);
    // R8 reset holds idle values even with lines asserted
    chk("reset code R8", code_lo, 4'hF);
    chk("reset flag R8", flag_lo, 1'b1);
    chk("reset code pos R8", code_hi, 4'h0);
    chk("reset flag pos R8", flag_hi, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // exhaustive stage sweep: R1 R2 R3 R4
    for (int v = 0; v < 512; v++) begin
      s_en_n  = v[8];
      s_req_n = v[7:0];
      #1;
      se = ref_stage(v[8], v[7:0]);
      if (v[8]) begin
        chk("stage disabled R2", {s_addr_n, s_grp_n, s_idle_n}, se);
      end else if (v[7:0] == 8'hFF) begin
        chk("stage idle R3", {s_addr_n, s_grp_n, s_idle_n}, se);
      end else begin
        chk("stage address R1", s_addr_n, se[4:2]);
        chk("stage group/idle R4", {s_grp_n, s_idle_n}, se[1:0]);
      end
    end

    // R8 one-cycle latency: line 15 then idle
    apply(1'b0, 16'h7FFF, "latency R8");
    apply(1'b0, 16'hFFFF, "all idle R5");
    apply(1'b1, 16'h0000, "disabled R9");
    apply(1'b1, 16'h1234, "disabled pattern R9");
    for (int k = 0; k < 16; k++) begin
      apply(1'b0, ~(16'h1 << k), "single line R5");
    end
    apply(1'b0, 16'h0000, "all low R5");
    apply(1'b0, 16'hFE00, "upper lowest R5");
    apply(1'b0, 16'hFF00, "lower only R5");
    for (int k = 0; k < 300; k++) begin
      logic [15:0] r;
      logic e;
      r = 16'($urandom);
      if (k % 3 == 0) r = r | 16'hFF00;
      e = ($urandom % 8) == 0;
      apply(e, r, "random R5");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule